// File: doc/BRIEF.md
# Video clock domain frequency converter

This block carries a marked video stream from a source pixel clock to a destination pixel clock running at a different rate. Typical pairs are roughly 304 MHz to roughly 426 MHz, or the same pair the other way round. Each source cycle that carries a tick is stored as one entry and delivered as one destination tick, whether it is an active pixel or a blanking cycle. An entry holds a 16-bit pixel, four sync markers and an active/blank flag. Horizontal and vertical blanking therefore survive the crossing cycle for cycle.

The crossing is an asynchronous FIFO. Its pointers are Gray coded and cross through synchroniser chains. When the FIFO is full, an arriving entry is discarded, the stored entries are kept, and a sticky overflow interrupt is raised in the source domain.

Software recovers from an aborted or stalled stream with a flush request. The request is synchronised into both domains and returns both pointers to zero. The source clock must be stopped before the converter's source is changed.

Top module: `vid_cdc_bridge`

## Requirements
- R1: While either reset is active, and after it until data arrives, `ovfIrq` is 0 and `dstTick` is 0.
- R2: Every accepted `srcTick` cycle, whether active or blanking, yields exactly one `dstTick` cycle. The read side advances by at most one entry per destination cycle.
- R3: Entries leave in arrival order with the same content:
  - `dstPixel` matches the source pixel.
  - `dstMarks` matches the source markers: bit0 line start, bit1 line end, bit2 frame start, bit3 frame end.
  - `dstActive` matches the source flag: 1 means a pixel, 0 means blanking.
- R4: `dstTick` is 1 only for a stored entry. With the FIFO empty, `dstTick` stays 0.
- R5: A `srcTick` that arrives while the FIFO is full is dropped. Entries already stored are delivered unchanged and in order. The first DEPTH entries written into an empty FIFO are never dropped.
- R6: A dropped entry sets `ovfIrq`, and `ovfIrq` stays set until a flush.
- R7: Holding `flushReq` for at least SYNC_STAGES+2 cycles of the slower clock has the following effects:
  - The FIFO is emptied and `ovfIrq` is cleared.
  - `srcTick` is ignored while the flush is seen.
  - `dstTick` stays 0 from the point the flush reaches the destination.
  - No discarded entry appears after release.
- R8: After a flush is released, new entries pass through from an empty FIFO as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source pixel clock |
| srcRstN | input | 1 | Source-domain reset, active low |
| srcTick | input | 1 | One stream cycle to transfer |
| srcPixel | input | 16 | Source pixel value |
| srcMarks | input | 4 | Sync markers (line start, line end, frame start, frame end) |
| srcActive | input | 1 | 1 for pixel, 0 for blanking |
| flushReq | input | 1 | Flush request level, asynchronous to both clocks |
| ovfIrq | output | 1 | Sticky overflow interrupt, source domain |
| dstClk | input | 1 | Destination pixel clock |
| dstRstN | input | 1 | Destination-domain reset, active low |
| dstTick | output | 1 | One delivered stream cycle |
| dstPixel | output | 16 | Delivered pixel value |
| dstMarks | output | 4 | Delivered sync markers |
| dstActive | output | 1 | Delivered pixel/blank flag |

## Verification
The bench builds the bridge with DEPTH=8 and SYNC_STAGES=2. A depth of eight absorbs the round-trip pointer latency when the destination runs faster, so the lossless phases run with no drops. The same depth fills within a few cycles once the destination clock is slowed below the 200 MHz source, which brings overflow, pointer wrap, the never-dropped first DEPTH entries and a flush of a part-filled FIFO within a short run. The destination period is switched at run time to cover both conversion directions.

// File: rtl/vcb_pkg.sv
package vcb_pkg;
  localparam int PIX_W  = 16;
  localparam int MARK_W = 4;

  typedef struct packed {
    logic              active;
    logic [MARK_W-1:0] marks;
    logic [PIX_W-1:0]  pixel;
  } vid_entry_t;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } vcb_strobe_t;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int i = 1; i < 32; i++) b = b ^ (g >> i);
    return b;
  endfunction
endpackage

// File: rtl/vcb_sync.sv
module vcb_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : gChain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[i] <= '0;
      else       stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/vcb_ctrl.sv
module vcb_ctrl import vcb_pkg::*; #(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          srcClk,
  input  logic          srcRstN,
  input  logic          srcTick,
  input  logic          flushReq,
  input  logic          dstClk,
  input  logic          dstRstN,
  output vcb_strobe_t   ctl,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic [PW-1:0] wrPtr,
  output logic [PW-1:0] rdPtr,
  output logic [PW-1:0] rdPtrAtSrc,
  output logic          flushSrc,
  output logic          flushDst,
  output logic          ovfIrq
);
  logic [PW-1:0] wrGray, rdGray, rdGrayAtSrc, wrGrayAtDst;
  logic          srcFull, dstEmpty, push, wrEn, rdEn;

  // flush level into each domain
  vcb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) uFlushSrc (
    .clk(srcClk), .rstN(srcRstN), .d(flushReq), .q(flushSrc));
  vcb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) uFlushDst (
    .clk(dstClk), .rstN(dstRstN), .d(flushReq), .q(flushDst));

  // Gray pointers across
  vcb_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) uRdToSrc (
    .clk(srcClk), .rstN(srcRstN), .d(rdGray), .q(rdGrayAtSrc));
  vcb_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) uWrToDst (
    .clk(dstClk), .rstN(dstRstN), .d(wrGray), .q(wrGrayAtDst));

  // source side: write pointer and overflow
  assign srcFull = (wrGray ^ rdGrayAtSrc) == {2'b11, {(PW-2){1'b0}}};
  assign push    = srcTick && !flushSrc;
  assign wrEn    = push && !srcFull;

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN) begin
      wrPtr  <= '0;
      wrGray <= '0;
      ovfIrq <= 1'b0;
    end else if (flushSrc) begin
      wrPtr  <= '0;
      wrGray <= '0;
      ovfIrq <= 1'b0;
    end else begin
      if (wrEn) begin
        wrPtr  <= wrPtr + PW'(1);
        wrGray <= PW'(bin2gray(32'(wrPtr + PW'(1))));
      end
      if (push && srcFull) ovfIrq <= 1'b1;
    end
  end

  // destination side: read pointer
  assign dstEmpty = (rdGray == wrGrayAtDst);
  assign rdEn     = !dstEmpty && !flushDst;

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) begin
      rdPtr  <= '0;
      rdGray <= '0;
    end else if (flushDst) begin
      rdPtr  <= '0;
      rdGray <= '0;
    end else if (rdEn) begin
      rdPtr  <= rdPtr + PW'(1);
      rdGray <= PW'(bin2gray(32'(rdPtr + PW'(1))));
    end
  end

  assign rdPtrAtSrc = PW'(gray2bin(32'(rdGrayAtSrc)));
  assign wrAddr     = wrPtr[AW-1:0];
  assign rdAddr     = rdPtr[AW-1:0];
  assign ctl        = '{wrEn: wrEn, rdEn: rdEn};
endmodule

// File: rtl/vcb_data.sv
module vcb_data import vcb_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          srcClk,
  input  logic          dstClk,
  input  logic          dstRstN,
  input  vcb_strobe_t   ctl,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  vid_entry_t    wrEntry,
  output vid_entry_t    outEntry,
  output logic          outTick
);
  vid_entry_t store [DEPTH];

  always_ff @(posedge srcClk) begin
    if (ctl.wrEn) store[wrAddr] <= wrEntry;
  end

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) begin
      outTick  <= 1'b0;
      outEntry <= '0;
    end else begin
      outTick <= ctl.rdEn;
      if (ctl.rdEn) outEntry <= store[rdAddr];
    end
  end
endmodule

// File: rtl/vid_cdc_bridge.sv
module vid_cdc_bridge import vcb_pkg::*; #(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic              srcTick,
  input  logic [PIX_W-1:0]  srcPixel,
  input  logic [MARK_W-1:0] srcMarks,
  input  logic              srcActive,
  input  logic              flushReq,
  output logic              ovfIrq,
  input  logic              dstClk,
  input  logic              dstRstN,
  output logic              dstTick,
  output logic [PIX_W-1:0]  dstPixel,
  output logic [MARK_W-1:0] dstMarks,
  output logic              dstActive
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  vcb_strobe_t   ctl;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [PW-1:0] wrPtr, rdPtr, rdPtrAtSrc;
  logic          flushSrc, flushDst;
  vid_entry_t    inEntry, outEntry;

  assign inEntry = '{active: srcActive, marks: srcMarks, pixel: srcPixel};

  vcb_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcTick(srcTick), .flushReq(flushReq),
    .dstClk(dstClk), .dstRstN(dstRstN), .ctl(ctl), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .rdPtrAtSrc(rdPtrAtSrc),
    .flushSrc(flushSrc), .flushDst(flushDst), .ovfIrq(ovfIrq));

  vcb_data #(.DEPTH(DEPTH)) uData (
    .srcClk(srcClk), .dstClk(dstClk), .dstRstN(dstRstN), .ctl(ctl),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrEntry(inEntry),
    .outEntry(outEntry), .outTick(dstTick));

  assign dstPixel  = outEntry.pixel;
  assign dstMarks  = outEntry.marks;
  assign dstActive = outEntry.active;
endmodule

// File: rtl/vcb_checker.sv
module vcb_checker #(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input logic          srcClk,
  input logic          srcRstN,
  input logic          dstClk,
  input logic          dstRstN,
  input logic          flushSrc,
  input logic          flushDst,
  input logic [PW-1:0] wrPtr,
  input logic [PW-1:0] rdPtr,
  input logic [PW-1:0] rdPtrAtSrc,
  input logic          ovfIrq,
  input logic          dstTick
);
  AST_OVF_STICKY: assert property (@(posedge srcClk) disable iff (!srcRstN)
    $fell(ovfIrq) |-> $past(flushSrc)); // R6

  AST_OCC_BOUND: assert property (@(posedge srcClk) disable iff (!srcRstN || flushSrc)
    PW'(wrPtr - rdPtrAtSrc) <= PW'(DEPTH)); // R5

  AST_WR_STEP: assert property (@(posedge srcClk) disable iff (!srcRstN)
    !flushSrc |=> PW'(wrPtr - $past(wrPtr)) <= PW'(1)); // R2

  AST_RD_STEP: assert property (@(posedge dstClk) disable iff (!dstRstN)
    !flushDst |=> PW'(rdPtr - $past(rdPtr)) <= PW'(1)); // R2

  AST_TICK_HAS_ENTRY: assert property (@(posedge dstClk) disable iff (!dstRstN)
    dstTick |-> PW'(rdPtr - $past(rdPtr)) == PW'(1)); // R4

  AST_FLUSH_SILENT: assert property (@(posedge dstClk) disable iff (!dstRstN)
    flushDst |=> !dstTick); // R7
endmodule

bind vid_cdc_bridge vcb_checker #(.DEPTH(DEPTH)) uChk (
  .srcClk(srcClk), .srcRstN(srcRstN), .dstClk(dstClk), .dstRstN(dstRstN),
  .flushSrc(flushSrc), .flushDst(flushDst), .wrPtr(wrPtr), .rdPtr(rdPtr),
  .rdPtrAtSrc(rdPtrAtSrc), .ovfIrq(ovfIrq), .dstTick(dstTick));

// File: tb/sim_vid_cdc_bridge.sv
`timescale 1ns/1ps
module sim_vid_cdc_bridge;
  localparam int DEPTH = 8;

  logic srcClk = 0, dstClk = 0, srcRstN = 0, dstRstN = 0;
  logic srcTick = 0, srcActive = 0, flushReq = 0;
  logic [15:0] srcPixel = '0;
  logic [3:0]  srcMarks = '0;
  logic ovfIrq, dstTick, dstActive;
  logic [15:0] dstPixel;
  logic [3:0]  dstMarks;

  real dstHalf = 1.5;
  int errors = 0, checks = 0, seq = 0, outCount = 0, skips = 0, phaseOut = 0;
  bit lenient = 0;
  logic [20:0] expQ[$];

  vid_cdc_bridge #(.DEPTH(DEPTH), .SYNC_STAGES(2)) u0 (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcTick(srcTick), .srcPixel(srcPixel),
    .srcMarks(srcMarks), .srcActive(srcActive), .flushReq(flushReq), .ovfIrq(ovfIrq),
    .dstClk(dstClk), .dstRstN(dstRstN), .dstTick(dstTick), .dstPixel(dstPixel),
    .dstMarks(dstMarks), .dstActive(dstActive));

  always #2.5 srcClk = ~srcClk;
  initial forever #(dstHalf) dstClk = ~dstClk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one source cycle; blanking on every third entry, markers walk
  task automatic srcCycle(input bit doPush, input bit record);
    @(negedge srcClk);
    if (doPush) begin
      srcTick   = 1;
      srcPixel  = seq[15:0];
      srcMarks  = 4'((seq * 5) % 16);
      srcActive = (seq % 3) != 0;
      if (record) expQ.push_back({srcActive, srcMarks, srcPixel});
      seq++;
    end else srcTick = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) srcCycle(0, 0);
  endtask

  always @(negedge dstClk) begin
    logic [20:0] got, e;
    bit found;
    if (dstRstN && dstTick) begin
      got = {dstActive, dstMarks, dstPixel};
      outCount++;
      if (!lenient) begin
        if (expQ.size() == 0) check(0, "R4/R7 unexpected dstTick", longint'(got), 0);
        else begin
          e = expQ.pop_front();
          check(got == e, "R3", longint'(got), longint'(e));
        end
      end else begin
        found = 0;
        while (expQ.size() > 0 && !found) begin
          e = expQ.pop_front();
          if (e == got) found = 1; else skips++;
        end
        check(found, "R5 order/content", longint'(got), 0);
        if (phaseOut < DEPTH) check(skips == 0, "R5 first DEPTH kept", skips, 0);
        phaseOut++;
      end
    end
  end

  initial begin
    #900000;
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(negedge srcClk);
    check(dstTick == 0, "R1 dstTick in reset", dstTick, 0);
    check(ovfIrq == 0, "R1 ovfIrq in reset", ovfIrq, 0);
    srcRstN = 1; dstRstN = 1;
    idle(10);
    check(dstTick == 0 && outCount == 0, "R1 idle after reset", outCount, 0);
    check(ovfIrq == 0, "R1 ovfIrq after reset", ovfIrq, 0);

    // fast destination, dense then sparse traffic
    for (int i = 0; i < 60; i++) srcCycle(1, 1);
    for (int i = 0; i < 40; i++) srcCycle(i % 3 != 1, 1);
    idle(30);
    check(expQ.size() == 0, "R2 all entries delivered", expQ.size(), 0);
    check(outCount == 87, "R2 one tick per entry", outCount, 87);
    check(ovfIrq == 0, "R6 no overflow when lossless", ovfIrq, 0);
    base = outCount;
    idle(20);
    check(outCount == base, "R4 idle when empty", outCount, base);

    // slow destination: overflow
    dstHalf = 6.0; idle(10);
    lenient = 1; skips = 0; phaseOut = 0; base = outCount;
    for (int i = 0; i < 40; i++) srcCycle(1, 1);
    check(ovfIrq == 1, "R6 overflow raised", ovfIrq, 1);
    idle(200);
    check(outCount - base < 40, "R5 entries dropped", outCount - base, 40);
    check(outCount - base >= DEPTH, "R5 stored entries kept", outCount - base, DEPTH);
    check(ovfIrq == 1, "R6 sticky", ovfIrq, 1);

    // flush with residual data
    phaseOut = DEPTH;
    for (int i = 0; i < 10; i++) srcCycle(1, 1);
    srcCycle(0, 0);
    flushReq = 1;
    for (int i = 0; i < 30; i++) srcCycle(i >= 10 && i < 16, 0); // ignored pushes
    check(ovfIrq == 0, "R7 ovfIrq cleared", ovfIrq, 0);
    flushReq = 0;
    expQ.delete();
    lenient = 0;
    base = outCount;
    idle(30);
    check(outCount == base, "R7 no stale or ignored data", outCount - base, 0);

    // traffic after flush, fast destination
    dstHalf = 1.5; idle(10);
    base = outCount;
    for (int i = 0; i < 30; i++) srcCycle(i % 4 != 0, 1);
    idle(30);
    check(expQ.size() == 0, "R8 drained after flush", expQ.size(), 0);
    check(outCount - base == 22, "R8 count after flush", outCount - base, 22);
    check(ovfIrq == 0, "R8 no overflow", ovfIrq, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule